// File: doc/BRIEF.md
# Variable-Width Packet Link Serializer and Deserializer

This block forms one end of a point-to-point packet link in which each direction carries 2, 4, 8, 16 or 32 lanes. The transmit half takes 32-bit packet words, each tagged as command or data. It cuts each word into narrow slices, one per bit time, and drives them onto the lane bus. Alongside the slices it drives a control line and a set of forwarded strobes, one per group of eight lanes. A strobe changes level on every bit time, so both of its edges carry data. The receive half watches its incoming strobes and collects slices. It hands a rebuilt 32-bit word and its command flag to the core once the final slice of the word has arrived.

Each direction settles its own lane count at the first clock after link reset is released. It keeps the requested width if both ends support it. Otherwise it falls back to the narrowest width they share. The chosen width holds until the next reset. The transmit state machine has three states. TX_NEGO waits for the width to settle and moves to TX_IDLE. TX_IDLE offers ready and moves to TX_SEND when a word is offered. TX_SEND shifts out slices. It stays in TX_SEND when a new word is accepted on the last slice, and it returns to TX_IDLE when no word is waiting. The receive state machine also has three states. RX_NEGO waits for the width. RX_GAP means no partial word is held, and it moves to RX_FILL on a slice that is not the last. RX_FILL collects slices and returns to RX_GAP when the final slice completes the word.

Top module: `vwl_link`

## Requirements
- R1: While rst_n is low, in_ready, tx_lanes, tx_ctl, tx_strobe and rx_word_valid are all 0.
- R2: Width code k selects 2<<k lanes (0=2, 1=4, 2=8, 3=16, 4=32), and bit k of a capability mask means width code k is supported. Each direction negotiates its width on the first clock after rst_n rises. If its requested code is at most 4 and set in both local_caps and peer_caps, that code is used. Otherwise the lowest bit set in both masks is used, and code 0 is used when they share none. The result appears on tx_width_code or rx_width_code.
- R3: Once negotiated, a width code stays unchanged until the next reset, whatever the request and capability inputs do.
- R4: A word at W lanes is sent over 32/W consecutive bit times. Bit time i carries word bits [i*W+W-1 : i*W] on tx_lanes[W-1:0], so the least significant slice goes first. Lanes W and above are 0.
- R5: tx_ctl equals the command flag of the word being sent during every one of its bit times.
- R6: Every bit time that presents a slice inverts tx_strobe[g] for each active group g, meaning g*8 < W. Inactive groups stay 0, and no strobe changes when no slice is presented.
- R7: in_ready is 1 only in TX_IDLE or during the last slice of a word. A word is taken when in_valid and in_ready are both 1 at a clock edge, and its first slice is presented in the next cycle. A word taken on a last slice follows with no idle bit time.
- R8: When no slice is being presented, tx_lanes and tx_ctl are 0.
- R9: The receiver takes one slice from rx_lanes on every cycle in which rx_strobe differs from its value in the previous cycle. In the cycle after the slice that completes a word, rx_word_valid is 1 for one cycle, with rx_word holding the rebuilt word and rx_cmd holding rx_ctl as seen on that last slice.
- R10: With transmit outputs looped back to receive inputs, every word and its command flag arrive once, in order, at each of the five widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Synchronous active-low link reset |
| local_caps | input | 5 | Width codes this end supports |
| peer_caps | input | 5 | Width codes the far end supports |
| tx_req_code | input | 3 | Requested width code, transmit direction |
| rx_req_code | input | 3 | Requested width code, receive direction |
| tx_width_code | output | 3 | Negotiated transmit width code |
| rx_width_code | output | 3 | Negotiated receive width code |
| in_valid | input | 1 | Upstream word offered |
| in_ready | output | 1 | Serializer can take a word |
| in_word | input | 32 | Packet word to send |
| in_cmd | input | 1 | 1 = command word, 0 = data word |
| tx_lanes | output | 32 | Outgoing lane bus |
| tx_ctl | output | 1 | Outgoing command/data line |
| tx_strobe | output | 4 | Forwarded strobe per 8-lane group |
| rx_lanes | input | 32 | Incoming lane bus |
| rx_ctl | input | 1 | Incoming command/data line |
| rx_strobe | input | 4 | Incoming strobes |
| rx_word_valid | output | 1 | Rebuilt word available |
| rx_word | output | 32 | Rebuilt word |
| rx_cmd | output | 1 | Command flag of rebuilt word |

## Verification
The bench checks the handoff on the last slice of a word. A serializer that drops ready one bit time too early leaves a gap between words, and one that raises it too early overwrites a slice that has not been sent. The 32-lane case sends each word in a single bit time, so a bad slice count or bad shift shows up there as a repeated or missing word. Mask cases check the fallback: an unsupported request, an out-of-range code and disjoint masks each select the wrong width if the priority between the request and the lowest shared width is reversed. Requests that change after reset would reveal a width register that keeps reloading.

// File: rtl/vwl_pkg.sv
package vwl_pkg;
    typedef enum logic [1:0] {TX_NEGO, TX_IDLE, TX_SEND} tx_state_e;
    typedef enum logic [1:0] {RX_NEGO, RX_GAP, RX_FILL} rx_state_e;
endpackage

// File: rtl/vwl_width_neg.sv
module vwl_width_neg #(
    parameter int NCODES = 5,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] req_code,
    input  logic [NCODES-1:0] local_caps,
    input  logic [NCODES-1:0] peer_caps,
    output logic [CODE_W-1:0] width_code,
    output logic              link_up
);
    logic [NCODES-1:0] common;
    logic [CODE_W-1:0] pick;

    always_comb begin
        common = local_caps & peer_caps;
        pick   = '0;
        for (int k = NCODES - 1; k >= 0; k--) begin
            if (common[k]) pick = CODE_W'(k);
        end
        if (int'(req_code) < NCODES) begin
            if (common[req_code]) pick = req_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_code <= '0;
            link_up    <= 1'b0;
        end else if (!link_up) begin
            width_code <= pick;
            link_up    <= 1'b1;
        end
    end
endmodule

// File: rtl/vwl_tx_ser.sv
module vwl_tx_ser
    import vwl_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int GROUP_LANES = 8,
    parameter int CODE_W      = 3,
    localparam int NGROUPS    = WORD_W / GROUP_LANES,
    localparam int LW         = $clog2(WORD_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_up,
    input  logic [CODE_W-1:0]  width_code,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               in_cmd,
    output logic [WORD_W-1:0]  tx_lanes,
    output logic               tx_ctl,
    output logic [NGROUPS-1:0] tx_strobe
);
    tx_state_e          state, state_nxt;
    logic [WORD_W-1:0]  shreg;
    logic               ctl_q;
    logic [LW-1:0]      cnt;
    logic [NGROUPS-1:0] strobe_q;
    logic [NGROUPS-1:0] gmask;
    logic [LW-1:0]      lane_cnt;
    logic [LW-1:0]      last_idx;
    logic [WORD_W-1:0]  lane_mask;
    logic               last_slice;
    logic               accept;

    assign lane_cnt   = LW'(2) << width_code;
    assign last_idx   = LW'(WORD_W >> (width_code + 1'b1)) - LW'(1);
    assign lane_mask  = {WORD_W{1'b1}} >> (LW'(WORD_W) - lane_cnt);
    assign last_slice = (state == TX_SEND) && (cnt == last_idx);
    assign in_ready   = (state == TX_IDLE) || last_slice;
    assign accept     = in_valid && in_ready;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        assign gmask[g] = (g * GROUP_LANES) < int'(lane_cnt);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_NEGO: if (link_up) state_nxt = TX_IDLE;
            TX_IDLE: if (in_valid) state_nxt = TX_SEND;
            TX_SEND: if (last_slice && !in_valid) state_nxt = TX_IDLE;
            default: state_nxt = TX_NEGO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_NEGO;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            ctl_q    <= 1'b0;
            cnt      <= '0;
            strobe_q <= '0;
        end else if (accept) begin
            shreg    <= in_word;
            ctl_q    <= in_cmd;
            cnt      <= '0;
            strobe_q <= strobe_q ^ gmask;
        end else if (state == TX_SEND && !last_slice) begin
            shreg    <= shreg >> lane_cnt;
            cnt      <= cnt + LW'(1);
            strobe_q <= strobe_q ^ gmask;
        end
    end

    always_comb begin
        tx_lanes  = (state == TX_SEND) ? (shreg & lane_mask) : '0;
        tx_ctl    = (state == TX_SEND) && ctl_q;
        tx_strobe = strobe_q;
    end
endmodule

// File: rtl/vwl_rx_des.sv
module vwl_rx_des
    import vwl_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int GROUP_LANES = 8,
    parameter int CODE_W      = 3,
    localparam int NGROUPS    = WORD_W / GROUP_LANES,
    localparam int LW         = $clog2(WORD_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_up,
    input  logic [CODE_W-1:0]  width_code,
    input  logic [WORD_W-1:0]  rx_lanes,
    input  logic               rx_ctl,
    input  logic [NGROUPS-1:0] rx_strobe,
    output logic               rx_word_valid,
    output logic [WORD_W-1:0]  rx_word,
    output logic               rx_cmd
);
    rx_state_e          state, state_nxt;
    logic [NGROUPS-1:0] strobe_prev;
    logic [WORD_W-1:0]  acc;
    logic [WORD_W-1:0]  acc_nxt;
    logic [LW-1:0]      cnt;
    logic [LW-1:0]      lane_cnt;
    logic [LW-1:0]      last_idx;
    logic [WORD_W-1:0]  lane_mask;
    logic               bit_time;
    logic               word_done;

    assign lane_cnt  = LW'(2) << width_code;
    assign last_idx  = LW'(WORD_W >> (width_code + 1'b1)) - LW'(1);
    assign lane_mask = {WORD_W{1'b1}} >> (LW'(WORD_W) - lane_cnt);
    assign bit_time  = (state != RX_NEGO) && (|(rx_strobe ^ strobe_prev));
    assign word_done = bit_time && (cnt == last_idx);
    assign acc_nxt   = (acc >> lane_cnt)
                     | ((rx_lanes & lane_mask) << (LW'(WORD_W) - lane_cnt));

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_NEGO: if (link_up) state_nxt = RX_GAP;
            RX_GAP:  if (bit_time && !word_done) state_nxt = RX_FILL;
            RX_FILL: if (word_done) state_nxt = RX_GAP;
            default: state_nxt = RX_NEGO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_NEGO;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_prev   <= '0;
            acc           <= '0;
            cnt           <= '0;
            rx_word_valid <= 1'b0;
            rx_word       <= '0;
            rx_cmd        <= 1'b0;
        end else begin
            strobe_prev   <= rx_strobe;
            rx_word_valid <= word_done;
            if (word_done) begin
                rx_word <= acc_nxt;
                rx_cmd  <= rx_ctl;
                cnt     <= '0;
                acc     <= '0;
            end else if (bit_time) begin
                acc <= acc_nxt;
                cnt <= cnt + LW'(1);
            end
        end
    end
endmodule

// File: rtl/vwl_link.sv
module vwl_link #(
    parameter int WORD_W      = 32,
    parameter int GROUP_LANES = 8,
    localparam int NCODES     = $clog2(WORD_W),
    localparam int CODE_W     = $clog2(NCODES),
    localparam int NGROUPS    = WORD_W / GROUP_LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCODES-1:0]  local_caps,
    input  logic [NCODES-1:0]  peer_caps,
    input  logic [CODE_W-1:0]  tx_req_code,
    input  logic [CODE_W-1:0]  rx_req_code,
    output logic [CODE_W-1:0]  tx_width_code,
    output logic [CODE_W-1:0]  rx_width_code,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               in_cmd,
    output logic [WORD_W-1:0]  tx_lanes,
    output logic               tx_ctl,
    output logic [NGROUPS-1:0] tx_strobe,
    input  logic [WORD_W-1:0]  rx_lanes,
    input  logic               rx_ctl,
    input  logic [NGROUPS-1:0] rx_strobe,
    output logic               rx_word_valid,
    output logic [WORD_W-1:0]  rx_word,
    output logic               rx_cmd
);
    logic tx_link_up;
    logic rx_link_up;

    vwl_width_neg #(.NCODES(NCODES), .CODE_W(CODE_W)) u_tx_neg (
        .clk(clk), .rst_n(rst_n), .req_code(tx_req_code),
        .local_caps(local_caps), .peer_caps(peer_caps),
        .width_code(tx_width_code), .link_up(tx_link_up)
    );

    vwl_width_neg #(.NCODES(NCODES), .CODE_W(CODE_W)) u_rx_neg (
        .clk(clk), .rst_n(rst_n), .req_code(rx_req_code),
        .local_caps(local_caps), .peer_caps(peer_caps),
        .width_code(rx_width_code), .link_up(rx_link_up)
    );

    vwl_tx_ser #(.WORD_W(WORD_W), .GROUP_LANES(GROUP_LANES), .CODE_W(CODE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .link_up(tx_link_up), .width_code(tx_width_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_cmd(in_cmd),
        .tx_lanes(tx_lanes), .tx_ctl(tx_ctl), .tx_strobe(tx_strobe)
    );

    vwl_rx_des #(.WORD_W(WORD_W), .GROUP_LANES(GROUP_LANES), .CODE_W(CODE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .link_up(rx_link_up), .width_code(rx_width_code),
        .rx_lanes(rx_lanes), .rx_ctl(rx_ctl), .rx_strobe(rx_strobe),
        .rx_word_valid(rx_word_valid), .rx_word(rx_word), .rx_cmd(rx_cmd)
    );
endmodule

// File: rtl/vwl_link_chk.sv
module vwl_link_chk #(
    parameter int WORD_W      = 32,
    parameter int GROUP_LANES = 8,
    parameter int CODE_W      = 3,
    localparam int NGROUPS    = WORD_W / GROUP_LANES
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_link_up,
    input logic [CODE_W-1:0]  tx_width_code,
    input logic [CODE_W-1:0]  rx_width_code,
    input logic               in_valid,
    input logic               in_ready,
    input logic [WORD_W-1:0]  tx_lanes,
    input logic [NGROUPS-1:0] tx_strobe,
    input logic [NGROUPS-1:0] rx_strobe,
    input logic               rx_word_valid
);
    int                 lanes_n;
    int                 slices;
    logic [WORD_W-1:0]  mask;
    logic [NGROUPS-1:0] gmask;
    int                 seen;

    always_comb begin
        lanes_n = 2 << tx_width_code;
        slices  = WORD_W / lanes_n;
        mask    = '0;
        for (int b = 0; b < WORD_W; b++) mask[b] = (b < lanes_n);
        for (int g = 0; g < NGROUPS; g++) gmask[g] = (g * GROUP_LANES < lanes_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          seen <= 0;
        else if (in_valid && in_ready)       seen <= 1;
        else if (seen != 0 && seen < slices) seen <= seen + 1;
        else                                 seen <= 0;
    end

    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_width_code) < 5) && (int'(rx_width_code) < 5)); // R2
    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_link_up |=> $stable(tx_width_code)); // R3
    AST_HIGH_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lanes & ~mask) == '0); // R4
    AST_IDLE_GROUPS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe & ~gmask) == '0); // R6
    AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (seen == 0 || seen == slices)); // R7
    AST_RX_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid |-> ($past(rx_strobe) != $past(rx_strobe, 2))); // R9
endmodule

bind vwl_link vwl_link_chk #(.WORD_W(WORD_W), .GROUP_LANES(GROUP_LANES), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_link_up(tx_link_up),
    .tx_width_code(tx_width_code), .rx_width_code(rx_width_code),
    .in_valid(in_valid), .in_ready(in_ready), .tx_lanes(tx_lanes),
    .tx_strobe(tx_strobe), .rx_strobe(rx_strobe), .rx_word_valid(rx_word_valid)
);

// File: tb/vwl_link_tb.sv
`timescale 1ns/1ps
module vwl_link_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  local_caps = 5'h1f, peer_caps = 5'h1f;
    logic [2:0]  tx_req_code = 3'd0, rx_req_code = 3'd0;
    logic [2:0]  tx_width_code, rx_width_code;
    logic        in_valid = 1'b0, in_ready, in_cmd = 1'b0;
    logic [31:0] in_word = '0;
    logic [31:0] tx_lanes, rx_word;
    logic        tx_ctl, rx_word_valid, rx_cmd;
    logic [3:0]  tx_strobe;

    always #2.5 clk = ~clk;

    vwl_link u_dut (
        .clk(clk), .rst_n(rst_n), .local_caps(local_caps), .peer_caps(peer_caps),
        .tx_req_code(tx_req_code), .rx_req_code(rx_req_code),
        .tx_width_code(tx_width_code), .rx_width_code(rx_width_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_cmd(in_cmd),
        .tx_lanes(tx_lanes), .tx_ctl(tx_ctl), .tx_strobe(tx_strobe),
        .rx_lanes(tx_lanes), .rx_ctl(tx_ctl), .rx_strobe(tx_strobe),
        .rx_word_valid(rx_word_valid), .rx_word(rx_word), .rx_cmd(rx_cmd)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // behavioural model of the link
    bit          m_busy, m_cmd, m_str;
    logic [31:0] m_word;
    int          m_idx, m_w, m_slices, m_code;
    bit          rxe_v, rxe_c;
    logic [31:0] rxe_w;
    int          sent;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pick_code(int req, logic [4:0] l, logic [4:0] p);
        logic [4:0] c = l & p;
        if (req < 5 && c[req]) return req;
        for (int k = 0; k < 5; k++) if (c[k]) return k;
        return 0;
    endfunction

    task automatic compare_outputs();
        logic [31:0] mask, exp_l;
        logic [3:0]  exp_s;
        bit          exp_r;
        mask  = (m_w == 32) ? 32'hffff_ffff : ((32'd1 << m_w) - 32'd1);
        exp_l = m_busy ? ((m_word >> (m_idx * m_w)) & mask) : 32'd0;
        exp_r = !m_busy || (m_idx == m_slices - 1);
        for (int g = 0; g < 4; g++) exp_s[g] = (g * 8 < m_w) ? m_str : 1'b0;
        chk(in_ready == exp_r, "R7", "in_ready", 64'(in_ready), 64'(exp_r));
        chk(tx_lanes == exp_l, m_busy ? "R4" : "R8", "tx_lanes", 64'(tx_lanes), 64'(exp_l));
        chk(tx_ctl == (m_busy && m_cmd), m_busy ? "R5" : "R8", "tx_ctl",
            64'(tx_ctl), 64'(m_busy && m_cmd));
        chk(tx_strobe == exp_s, "R6", "tx_strobe", 64'(tx_strobe), 64'(exp_s));
        chk(tx_width_code == 3'(m_code), "R3", "tx_width_code", 64'(tx_width_code), 64'(m_code));
        chk(rx_word_valid == rxe_v, "R9", "rx_word_valid", 64'(rx_word_valid), 64'(rxe_v));
        if (rxe_v && rx_word_valid) begin
            chk(rx_word == rxe_w, "R10", "rx_word", 64'(rx_word), 64'(rxe_w));
            chk(rx_cmd == rxe_c, "R10", "rx_cmd", 64'(rx_cmd), 64'(rxe_c));
        end
    endtask

    // called at a falling edge: compare, drive, predict the next rising edge
    task automatic step(input bit want);
        bit acc, rdy;
        logic [31:0] w;
        bit c;
        compare_outputs();
        w   = $urandom;
        c   = 1'($urandom % 2);
        in_valid = want;
        in_word  = w;
        in_cmd   = c;
        rdy   = !m_busy || (m_idx == m_slices - 1);
        acc   = want && rdy;
        rxe_v = m_busy && (m_idx == m_slices - 1);
        rxe_w = m_word;
        rxe_c = m_cmd;
        if (acc) begin
            m_busy = 1; m_word = w; m_cmd = c; m_idx = 0; m_str = ~m_str; sent++;
        end else if (m_busy) begin
            if (m_idx == m_slices - 1) m_busy = 0;
            else begin m_idx++; m_str = ~m_str; end
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input int txr, input int rxr, input logic [4:0] l, input logic [4:0] p);
        int et, er;
        rst_n = 1'b0; in_valid = 1'b0;
        tx_req_code = 3'(txr); rx_req_code = 3'(rxr); local_caps = l; peer_caps = p;
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b0 && tx_lanes == '0 && tx_ctl == 1'b0 && tx_strobe == '0
            && rx_word_valid == 1'b0, "R1", "outputs in reset",
            {in_ready, tx_ctl, rx_word_valid, tx_strobe, tx_lanes}, 64'd0);
        rst_n = 1'b1;
        m_busy = 0; m_str = 0; m_idx = 0; rxe_v = 0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R2", "ready during width latch", 64'(in_ready), 64'd0);
        @(negedge clk);
        et = pick_code(txr, l, p);
        er = pick_code(rxr, l, p);
        chk(tx_width_code == 3'(et), "R2", "tx_width_code", 64'(tx_width_code), 64'(et));
        chk(rx_width_code == 3'(er), "R2", "rx_width_code", 64'(rx_width_code), 64'(er));
        m_code = et; m_w = 2 << et; m_slices = 32 / m_w;
    endtask

    task automatic run_width(input int code);
        do_reset(code, code, 5'h1f, 5'h1f);
        // R3: request and caps change after the width is latched
        tx_req_code = 3'(4 - code); rx_req_code = 3'd7; local_caps = 5'b00001;
        sent = 0;
        while (sent < 8) step(1'b1);
        while (sent < 24) step(($urandom % 4) != 0);
        repeat (m_slices + 3) step(1'b0);
    endtask

    initial begin
        @(negedge clk);
        for (int c = 0; c < 5; c++) run_width(c);
        do_reset(5, 1, 5'b11100, 5'b01110);   // R2 invalid / unsupported -> lowest common
        do_reset(3, 4, 5'b11111, 5'b10111);   // R2 independent directions
        do_reset(1, 2, 5'b00001, 5'b00010);   // R2 nothing shared -> code 0
        do_reset(7, 2, 5'b11000, 5'b11000);   // R2 out-of-range request
        repeat (4) step(1'b0);                // R8 idle at width 16
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule